// File: doc/BRIEF.md
# System Control Register Bank

This block is a small bank of control and status registers for a development board. It sits on a simple register bus inside a 4 KB little-endian window. The bus has a 12-bit byte address, separate read and write strobes, and 32-bit data. Through this bank, software can:

- drive a configurable number of active-high LEDs;
- read the board buttons and, when that option is built in, a bank of switches;
- keep a miscellaneous control word and, when that option is built in, a debug-control word;
- read and load two timebase counters.

The two timebase counters advance at 1 Hz and 100 Hz. Each counter takes its enable from its own divider of the system clock. Writing a counter loads the written value and restarts that counter's divider, so counting continues from the loaded value a full period later.

Parameters set the LED count (elaboration stops with an error if it is below 1 or above the supported maximum), the button and switch widths, the two divider periods, and whether the switch and debug-control registers exist. An access to an absent or unknown register is answered with read data of zero. It also produces a one-cycle error pulse. Address bits [1:0] are ignored, so every register is a 32-bit word.

Top module: `sysctl_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, LED outputs, miscellaneous word, read data, error pulse and both counters are zero. The first reads after reset release return counter values of 0.
- R2: A write to offset 0x000 keeps only bits [NUM_LEDS-1:0] of the write data. Bit i drives `led_o[i]`, active high. A read of 0x000 returns the kept bits, zero-extended.
- R3: Offset 0x04C holds a 32-bit word that reads back exactly as last written and is driven on `misc_o`.
- R4: Offset 0x008 reads `buttons_i`, zero-extended. A write to 0x008 changes nothing and is a bad access.
- R5: The counter at 0x010 increments once every SLOW_PERIOD clock cycles, and the counter at 0x014 once every FAST_PERIOD cycles. Over any window of k·period cycles without a write, a counter gains exactly k.
- R6: A write to 0x010 or 0x014 loads the written value and restarts that counter's divider. A read in the cycle after the write returns the value. The first increment lands at the edge that ends cycle w+period, where w is the write cycle. A write that coincides with a tick wins, and that tick is lost.
- R7: Read data appears on `bus_rdata` after the clock edge that ends the read cycle. It holds until the next read, and counter reads return the value from before any increment in the same cycle.
- R8: An access to an offset that is not decoded returns read data of 0 and has no effect on any register. It raises `bus_err` for exactly the one cycle after each such access.
- R9: Offset 0x050 reads `switches_i` only when HAS_SWITCHES is set. Otherwise 0x050 is a bad access.
- R10: Offset 0x004 is a 32-bit read/write word only when HAS_DBGCTRL is set. Otherwise 0x004 is a bad access.
- R11: A counter holding 0xFFFFFFFF wraps to 0 on its next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a bad access |
| buttons_i | input | BTN_W | Board button levels |
| switches_i | input | SW_W | Board switch levels |
| led_o | output | NUM_LEDS | Active-high LED drives |
| misc_o | output | 32 | Miscellaneous control word |

## Verification
A counter load from the bus and a divider tick can fall in the same cycle. The bench provokes this on purpose: it writes a counter, waits exactly period−1 idle cycles, then writes it again, so that the second write lands on the tick edge. It then judges the result: the readback must equal the second written value, not that value plus one. A random traffic phase runs two configurations with different periods against a behavioural model each cycle. That phase repeats the collision at many phases and also mixes in reads in the same cycle as a load.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    // Word offsets inside the 4 KB window
    localparam logic [BUS_AW-1:0] OFS_LED  = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_DBG  = 12'h004;
    localparam logic [BUS_AW-1:0] OFS_BTN  = 12'h008;
    localparam logic [BUS_AW-1:0] OFS_SLOW = 12'h010;
    localparam logic [BUS_AW-1:0] OFS_FAST = 12'h014;
    localparam logic [BUS_AW-1:0] OFS_MISC = 12'h04C;
    localparam logic [BUS_AW-1:0] OFS_SW   = 12'h050;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LED,
        SEL_DBG,
        SEL_BTN,
        SEL_SLOW,
        SEL_FAST,
        SEL_MISC,
        SEL_SW
    } reg_sel_e;

    typedef struct packed {
        logic [BUS_DW-1:0] count;
        logic [31:0]       phase;
    } timebase_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter bit HAS_SWITCHES = 1'b0,
    parameter bit HAS_DBGCTRL  = 1'b0
) (
    input  logic [BUS_AW-1:0] addr,
    output reg_sel_e          sel,
    output logic              read_only
);

    logic [BUS_AW-1:0] word_ofs;

    // byte lanes are not decoded: every register is one full word
    assign word_ofs = addr & ~BUS_AW'(3);

    always_comb begin
        sel       = SEL_NONE;
        read_only = 1'b0;
        case (word_ofs)
            OFS_LED:  sel = SEL_LED;
            OFS_DBG:  if (HAS_DBGCTRL) sel = SEL_DBG;
            OFS_BTN:  begin
                sel       = SEL_BTN;
                read_only = 1'b1;
            end
            OFS_SLOW: sel = SEL_SLOW;
            OFS_FAST: sel = SEL_FAST;
            OFS_MISC: sel = SEL_MISC;
            OFS_SW:   if (HAS_SWITCHES) begin
                sel       = SEL_SW;
                read_only = 1'b1;
            end
            default:  sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sysctl_timebase.sv
module sysctl_timebase
    import sysctl_pkg::*;
#(
    parameter int unsigned PERIOD = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BUS_DW-1:0] load_val_i,
    output logic [BUS_DW-1:0] count_o
);

    localparam logic [31:0] LAST_PHASE = 32'(PERIOD - 1);

    if (PERIOD < 1) begin : g_bad_period
        $error("sysctl_timebase: PERIOD must be at least 1");
    end

    timebase_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (load_i) begin
            // a load restarts the divider and overrides a coincident tick
            tb_d.count = load_val_i;
            tb_d.phase = '0;
        end else if (tb_q.phase == LAST_PHASE) begin
            tb_d.count = tb_q.count + 1'b1;
            tb_d.phase = '0;
        end else begin
            tb_d.phase = tb_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign count_o = tb_q.count;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_LEDS     = 2,
    parameter int unsigned MAX_LEDS     = 32,
    parameter int unsigned BTN_W        = 2,
    parameter int unsigned SW_W         = 8,
    parameter bit          HAS_SWITCHES = 1'b0,
    parameter bit          HAS_DBGCTRL  = 1'b0,
    parameter int unsigned SYS_CLK_HZ   = 50000000,
    parameter int unsigned SLOW_PERIOD  = SYS_CLK_HZ,
    parameter int unsigned FAST_PERIOD  = SYS_CLK_HZ / 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [BUS_DW-1:0]   bus_rdata,
    output logic                bus_err,
    input  logic [BTN_W-1:0]    buttons_i,
    input  logic [SW_W-1:0]     switches_i,
    output logic [NUM_LEDS-1:0] led_o,
    output logic [BUS_DW-1:0]   misc_o
);

    localparam int unsigned N_TB = 2;   // index 0: 1 Hz, index 1: 100 Hz

    // R2: LED count outside the supported range stops elaboration
    if (NUM_LEDS < 1 || NUM_LEDS > MAX_LEDS) begin : g_bad_leds
        $error("sysctl_regfile: NUM_LEDS out of range");
    end
    if (BTN_W > BUS_DW || SW_W > BUS_DW) begin : g_bad_inputs
        $error("sysctl_regfile: input bank wider than the data bus");
    end

    typedef struct packed {
        logic [NUM_LEDS-1:0] led;
        logic [BUS_DW-1:0]   dbg;
        logic [BUS_DW-1:0]   misc;
        logic [BUS_DW-1:0]   rdata;
        logic                err;
    } regs_t;

    regs_t            regs_d, regs_q;
    reg_sel_e         sel;
    logic             read_only;
    logic             bad_access;
    logic [BUS_DW-1:0] rd_val;
    logic [BUS_DW-1:0] tb_count [N_TB];
    logic [N_TB-1:0]   tb_load;

    sysctl_decode #(
        .HAS_SWITCHES(HAS_SWITCHES),
        .HAS_DBGCTRL (HAS_DBGCTRL)
    ) u_decode (
        .addr     (bus_addr),
        .sel      (sel),
        .read_only(read_only)
    );

    for (genvar g = 0; g < N_TB; g++) begin : g_tb
        localparam int unsigned TB_PERIOD = (g == 0) ? SLOW_PERIOD : FAST_PERIOD;
        localparam reg_sel_e    TB_SEL    = (g == 0) ? SEL_SLOW : SEL_FAST;

        assign tb_load[g] = bus_wr && (sel == TB_SEL);

        sysctl_timebase #(
            .PERIOD(TB_PERIOD)
        ) u_timebase (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (tb_load[g]),
            .load_val_i(bus_wdata),
            .count_o   (tb_count[g])
        );
    end

    // read multiplexer: absent or unknown offsets return zero
    always_comb begin
        case (sel)
            SEL_LED:  rd_val = BUS_DW'(regs_q.led);
            SEL_DBG:  rd_val = regs_q.dbg;
            SEL_BTN:  rd_val = BUS_DW'(buttons_i);
            SEL_SLOW: rd_val = tb_count[0];
            SEL_FAST: rd_val = tb_count[1];
            SEL_MISC: rd_val = regs_q.misc;
            SEL_SW:   rd_val = BUS_DW'(switches_i);
            default:  rd_val = '0;
        endcase
    end

    assign bad_access = (bus_rd || bus_wr) &&
                        ((sel == SEL_NONE) || (bus_wr && read_only));

    always_comb begin
        regs_d     = regs_q;
        regs_d.err = bad_access;
        if (bus_rd) regs_d.rdata = rd_val;
        if (bus_wr && !bad_access) begin
            case (sel)
                SEL_LED:  regs_d.led  = bus_wdata[NUM_LEDS-1:0];
                SEL_DBG:  regs_d.dbg  = bus_wdata;
                SEL_MISC: regs_d.misc = bus_wdata;
                default:  regs_d.led  = regs_q.led;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata = regs_q.rdata;
    assign bus_err   = regs_q.err;
    assign led_o     = regs_q.led;
    assign misc_o    = regs_q.misc;

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
    parameter int unsigned NUM_LEDS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [31:0]         bus_rdata,
    input logic                bus_err,
    input logic [NUM_LEDS-1:0] led_o,
    input logic [31:0]         misc_o,
    input logic [31:0]         slow_cnt,
    input logic [31:0]         fast_cnt
);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr));

    p_bad_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && $past(bus_rd) && !$past(bus_wr)) |-> (bus_rdata == 32'd0));

    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

    p_led_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(led_o));

    p_misc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(misc_o));

    p_slow_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_wr) && (slow_cnt != $past(slow_cnt)))
            |-> (slow_cnt == $past(slow_cnt) + 32'd1));

    p_fast_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_wr) && (fast_cnt != $past(fast_cnt)))
            |-> (fast_cnt == $past(fast_cnt) + 32'd1));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
    .NUM_LEDS(NUM_LEDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .led_o    (led_o),
    .misc_o   (misc_o),
    .slow_cnt (tb_count[0]),
    .fast_cnt (tb_count[1])
);

// File: tb/sysctl_regfile_tb_top.sv
module sysctl_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  buttons = '0;
    logic [7:0]  switches = '0;

    logic [31:0] rdata0, rdata1, misc0, misc1;
    logic        err0, err1;
    logic [1:0]  led0;
    logic [3:0]  led1;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sysctl_regfile #(
        .SLOW_PERIOD(20), .FAST_PERIOD(7)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .bus_err(err0), .buttons_i(buttons), .switches_i(switches),
        .led_o(led0), .misc_o(misc0)
    );

    sysctl_regfile #(
        .NUM_LEDS(4), .HAS_SWITCHES(1'b1), .HAS_DBGCTRL(1'b1),
        .SLOW_PERIOD(13), .FAST_PERIOD(5)
    ) dut_opt_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .bus_err(err1), .buttons_i(buttons), .switches_i(switches),
        .led_o(led1), .misc_o(misc1)
    );

    // ---------------- behavioural reference model ----------------
    int unsigned per  [2][2] = '{'{20, 7}, '{13, 5}};
    int unsigned nled [2]    = '{2, 4};
    bit          hsw  [2]    = '{1'b0, 1'b1};
    bit          hdbg [2]    = '{1'b0, 1'b1};

    bit [31:0]   m_led [2], m_dbg [2], m_misc [2], m_rdata [2];
    bit          m_err [2];
    bit [31:0]   m_cnt [2][2];
    int unsigned m_ph  [2][2];

    always @(posedge clk or negedge rst_n) begin : model
        bit [11:0] wa;
        bit        known, ro;
        bit [31:0] rv;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_led[c] = 0; m_dbg[c] = 0; m_misc[c] = 0;
                m_rdata[c] = 0; m_err[c] = 0;
                for (int k = 0; k < 2; k++) begin
                    m_cnt[c][k] = 0; m_ph[c][k] = 0;
                end
            end
        end else begin
            wa = bus_addr & 12'hFFC;
            for (int c = 0; c < 2; c++) begin
                known = 1'b1; ro = 1'b0; rv = 0;
                case (wa)
                    12'h000: rv = m_led[c];
                    12'h004: if (hdbg[c]) rv = m_dbg[c]; else known = 1'b0;
                    12'h008: begin rv = {30'd0, buttons}; ro = 1'b1; end
                    12'h010: rv = m_cnt[c][0];
                    12'h014: rv = m_cnt[c][1];
                    12'h04C: rv = m_misc[c];
                    12'h050: if (hsw[c]) begin rv = {24'd0, switches}; ro = 1'b1; end
                             else known = 1'b0;
                    default: known = 1'b0;
                endcase
                m_err[c] = (bus_rd || bus_wr) && (!known || (bus_wr && ro));
                if (bus_rd) m_rdata[c] = known ? rv : 32'd0;
                for (int k = 0; k < 2; k++) begin
                    if (bus_wr && wa == (k == 0 ? 12'h010 : 12'h014)) begin
                        m_cnt[c][k] = bus_wdata; m_ph[c][k] = 0;
                    end else if (m_ph[c][k] == per[c][k] - 1) begin
                        m_cnt[c][k] = m_cnt[c][k] + 1; m_ph[c][k] = 0;
                    end else begin
                        m_ph[c][k] = m_ph[c][k] + 1;
                    end
                end
                if (bus_wr && known && !ro) begin
                    if (wa == 12'h000) m_led[c] = bus_wdata & ((32'd1 << nled[c]) - 1);
                    if (wa == 12'h004) m_dbg[c] = bus_wdata;
                    if (wa == 12'h04C) m_misc[c] = bus_wdata;
                end
            end
        end
    end

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            check32("R2 led cfg0",   {30'd0, led0},  m_led[0]);
            check32("R2 led cfg1",   {28'd0, led1},  m_led[1]);
            check32("R3 misc cfg0",  misc0,          m_misc[0]);
            check32("R3 misc cfg1",  misc1,          m_misc[1]);
            check32("R7 rdata cfg0", rdata0,         m_rdata[0]);
            check32("R7 rdata cfg1", rdata1,         m_rdata[1]);
            check32("R8 err cfg0",   {31'd0, err0},  {31'd0, m_err[0]});
            check32("R8 err cfg1",   {31'd0, err1},  {31'd0, m_err[1]});
        end
    end

    task automatic step(input logic rd, input logic wr, input logic [11:0] a,
                        input logic [31:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 12'h000, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        logic [31:0] base;
        logic [31:0] lf;
        logic [11:0] offs [9];
        offs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
                 12'h014, 12'h04C, 12'h050, 12'hFFC};

        // R1: state during reset
        repeat (3) @(negedge clk);
        check32("R1 led0 in reset",  {30'd0, led0}, 32'd0);
        check32("R1 led1 in reset",  {28'd0, led1}, 32'd0);
        check32("R1 misc in reset",  misc0, 32'd0);
        check32("R1 rdata in reset", rdata0, 32'd0);
        check32("R1 err in reset",   {31'd0, err0}, 32'd0);

        @(negedge clk);
        rst_n = 1'b1; bus_rd = 1'b1; bus_addr = 12'h010;
        step(1'b1, 1'b0, 12'h014, 32'd0);
        check32("R1 slow count after reset", rdata0, 32'd0);
        check32("R1 slow count after reset opt", rdata1, 32'd0);
        idle(1);
        check32("R1 fast count after reset", rdata0, 32'd0);
        check32("R1 fast count after reset opt", rdata1, 32'd0);

        // R2: LED masking
        step(1'b0, 1'b1, 12'h000, 32'hFFFF_FFFD);
        idle(1);
        check32("R2 led 2-bit", {30'd0, led0}, 32'h1);
        check32("R2 led 4-bit", {28'd0, led1}, 32'hD);
        step(1'b1, 1'b0, 12'h000, 32'd0);
        idle(1);
        check32("R2 led readback", rdata0, 32'h1);
        check32("R2 led readback opt", rdata1, 32'hD);

        // R3: misc word
        step(1'b0, 1'b1, 12'h04C, 32'hA5A5_1234);
        step(1'b1, 1'b0, 12'h04C, 32'd0);
        idle(1);
        check32("R3 misc out", misc0, 32'hA5A5_1234);
        check32("R3 misc readback", rdata0, 32'hA5A5_1234);
        check32("R3 misc readback opt", rdata1, 32'hA5A5_1234);

        // R4: buttons read-only
        step(1'b1, 1'b0, 12'h008, 32'd0);
        buttons = 2'b10;
        idle(1);
        check32("R4 buttons read", rdata0, 32'h2);
        check32("R4 buttons read no err", {31'd0, err0}, 32'd0);
        step(1'b0, 1'b1, 12'h008, 32'hFFFF);
        idle(1);
        check32("R4 buttons write err", {31'd0, err0}, 32'd1);
        check32("R4 buttons write err opt", {31'd0, err1}, 32'd1);
        check32("R4 led untouched", {30'd0, led0}, 32'h1);

        // R7: read data holds across idle and writes
        step(1'b1, 1'b0, 12'h000, 32'd0);
        step(1'b0, 1'b1, 12'h04C, 32'd0);
        idle(3);
        check32("R7 rdata hold", rdata0, 32'h1);
        check32("R7 misc cleared", misc0, 32'd0);

        // R8: undecoded offsets
        step(1'b1, 1'b0, 12'h00C, 32'd0);
        idle(1);
        check32("R8 bad read data", rdata0, 32'd0);
        check32("R8 bad read err", {31'd0, err0}, 32'd1);
        idle(1);
        check32("R8 err single cycle", {31'd0, err0}, 32'd0);
        step(1'b0, 1'b1, 12'hFFC, 32'h3);
        idle(1);
        check32("R8 bad write err", {31'd0, err0}, 32'd1);
        check32("R8 bad write no effect", {30'd0, led0}, 32'h1);
        step(1'b1, 1'b0, 12'h000, 32'd0);
        idle(1);
        check32("R8 led readback after bad write", rdata0, 32'h1);

        // R9: switches option
        switches = 8'h5A;
        step(1'b1, 1'b0, 12'h050, 32'd0);
        idle(1);
        check32("R9 absent switches err", {31'd0, err0}, 32'd1);
        check32("R9 absent switches data", rdata0, 32'd0);
        check32("R9 present switches err", {31'd0, err1}, 32'd0);
        check32("R9 present switches data", rdata1, 32'h5A);

        // R10: debug-control option
        step(1'b0, 1'b1, 12'h004, 32'h0000_1234);
        idle(1);
        check32("R10 absent dbg write err", {31'd0, err0}, 32'd1);
        check32("R10 present dbg write err", {31'd0, err1}, 32'd0);
        step(1'b1, 1'b0, 12'h004, 32'd0);
        idle(1);
        check32("R10 absent dbg read", rdata0, 32'd0);
        check32("R10 present dbg read", rdata1, 32'h0000_1234);

        // R5: fast counter gains 3 over 21 cycles (period 7)
        step(1'b1, 1'b0, 12'h014, 32'd0);
        idle(1);
        base = rdata0;
        idle(19);
        step(1'b1, 1'b0, 12'h014, 32'd0);
        idle(1);
        check32("R5 fast rate", rdata0, base + 32'd3);
        // R5: slow counter gains 2 over 40 cycles (period 20)
        step(1'b1, 1'b0, 12'h010, 32'd0);
        idle(1);
        base = rdata0;
        idle(38);
        step(1'b1, 1'b0, 12'h010, 32'd0);
        idle(1);
        check32("R5 slow rate", rdata0, base + 32'd2);

        // R6: load and divider restart
        step(1'b0, 1'b1, 12'h014, 32'd100);
        step(1'b1, 1'b0, 12'h014, 32'd0);
        idle(1);
        check32("R6 load visible", rdata0, 32'd100);
        idle(4);
        step(1'b1, 1'b0, 12'h014, 32'd0);
        step(1'b1, 1'b0, 12'h014, 32'd0);
        check32("R6 no tick before period", rdata0, 32'd100);
        idle(1);
        check32("R6 first tick after period", rdata0, 32'd101);
        // R6: load coinciding with a tick wins
        step(1'b0, 1'b1, 12'h014, 32'd500);
        idle(6);
        step(1'b0, 1'b1, 12'h014, 32'd900);
        step(1'b1, 1'b0, 12'h014, 32'd0);
        idle(1);
        check32("R6 load beats tick", rdata0, 32'd900);

        // R11: wrap
        step(1'b0, 1'b1, 12'h014, 32'hFFFF_FFFF);
        idle(7);
        step(1'b1, 1'b0, 12'h014, 32'd0);
        idle(1);
        check32("R11 wrap to zero", rdata0, 32'd0);

        // random traffic, judged against the model every cycle
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 1500; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            if (lf[20:17] == 4'd0) buttons = lf[1:0];
            if (lf[24:21] == 4'd0) switches = lf[9:2];
            step(lf[0], lf[1], offs[lf[7:4] % 9] | {10'd0, lf[9:8]},
                 {lf[31:16], lf[15:0] ^ 16'h5A5A});
        end
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule